// File: doc/BRIEF.md
# Bidirectional Gate-Scan Shift Register

This block generates the row-select sequence for a display gate driver. A single start pulse, sampled on the rising clock edge, enters one end of a chain of stages and moves one stage per clock. Each stage drives one scan line. When the pulse leaves the last active stage, a carry pulse is sent to the next driver in a cascade. That carry pulse is timed on the falling clock edge.

A direction input selects which end is the entry. The two cascade ports are modelled as separate input and output pins. A drive flag on each port tells the pad which side currently acts as the output. A static length select shortens the chain from 154 to 150 stages. In the short chain, four stages in the middle are skipped and held low. Three active-high blanking inputs each force one rotating group of scan lines low at once, without any clock. The chain contents are kept while a line is blanked.

Top module: `gate_scan_chain`

## Requirements
- R1: While `rst_n` is low, all scan lines, both cascade outputs and the chain contents are 0.
- R2: With `dir_fwd`=1, `head_in` is sampled on each rising edge. After k rising edges a sampled 1 appears on scan line k (`scan[k-1]`).
- R3: With `dir_fwd`=0, `tail_in` is sampled and moves from line 154 toward line 1, one line per rising edge.
- R4: With `short_mode`=0, the exit cascade output rises at the 154th falling edge after the pulse is sampled and falls at the 155th. The exit output is `tail_out` when forward and `head_out` when reverse.
- R5: With `short_mode`=1, lines 76 to 79 stay 0 and are skipped, so line 75 feeds line 80 in one clock in either direction. The exit output rises at the 150th falling edge and falls at the 151st.
- R6: A high `blank[p]` forces every line of phase p to 0 straight away, with no clock. The chain keeps shifting, and when `blank[p]` drops the lines show the current contents.
- R7: With `short_mode`=0, line n belongs to phase (n-1) mod 3, and phase 0 is `blank[0]`.
- R8: With `short_mode`=1, lines 1 to 75 keep the R7 phases, and line n≥80 belongs to phase (n-5) mod 3. So line 80 is phase 0 and line 154 is phase 2.
- R9: `tail_drive`=`dir_fwd` and `head_drive`=~`dir_fwd`. The cascade output on the entry side is 0. The input on the exit side is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_fwd | input | 1 | 1: line 1 toward line 154; 0: reverse |
| short_mode | input | 1 | Static length select, 1 = 150 active lines |
| head_in | input | 1 | Start input at the line-1 end |
| tail_in | input | 1 | Start input at the line-154 end |
| blank | input | 3 | Per-phase forcing of lines low |
| scan | output | 154 | Scan lines, bit n-1 is line n |
| head_out | output | 1 | Cascade output at the line-1 end |
| tail_out | output | 1 | Cascade output at the line-154 end |
| head_drive | output | 1 | Line-1 end port acts as output |
| tail_drive | output | 1 | Line-154 end port acts as output |

## Verification
A single pulse runs the full length in each direction and each length mode. This separates the skip path from the full path and the rising-edge entry from the falling-edge carry timing. A block of contiguous ones is then held while each blank phase is raised alone. This separates the two phase mappings, and it shows that the contents survive a blank. Long random streams, with noise on the exit-side input, are compared on every clock against a behavioural chain. These streams catch mistakes in the skip and phase logic that a lone pulse would miss.

// File: rtl/gate_scan_chain.sv
module gate_scan_chain #(
  parameter int N_STAGE    = 154,
  parameter int N_HOLD     = 4,
  parameter int HOLD_FIRST = 76,
  parameter int N_PH       = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dir_fwd,
  input  logic               short_mode,
  input  logic               head_in,
  input  logic               tail_in,
  input  logic [N_PH-1:0]    blank,
  output logic [N_STAGE-1:0] scan,
  output logic               head_out,
  output logic               tail_out,
  output logic               head_drive,
  output logic               tail_drive
);
  localparam int HL = HOLD_FIRST - 1;
  localparam int HH = HL + N_HOLD - 1;
  localparam int PV = HL - 1;
  localparam int NX = HH + 1;

  logic [N_STAGE-1:0] sr, nxt;
  logic cas_q;

  for (genvar i = 0; i < N_STAGE; i++) begin : g_st
    logic from_lo, from_hi, held, en_off;
    localparam int PL = i % N_PH;
    localparam int PS = (i > HH) ? (i - N_HOLD) % N_PH : PL;

    if (i == 0) begin : g_lo_end
      assign from_lo = head_in;
    end else if (i == NX) begin : g_lo_skip
      assign from_lo = short_mode ? sr[PV] : sr[i-1];
    end else begin : g_lo
      assign from_lo = sr[i-1];
    end

    if (i == N_STAGE - 1) begin : g_hi_end
      assign from_hi = tail_in;
    end else if (i == PV) begin : g_hi_skip
      assign from_hi = short_mode ? sr[NX] : sr[i+1];
    end else begin : g_hi
      assign from_hi = sr[i+1];
    end

    if (i >= HL && i <= HH) begin : g_hold
      assign held = short_mode;
    end else begin : g_live
      assign held = 1'b0;
    end

    assign en_off  = short_mode ? blank[PS] : blank[PL];
    assign nxt[i]  = ~held & (dir_fwd ? from_lo : from_hi);
    assign scan[i] = sr[i] & ~held & ~en_off;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sr <= '0;
    else        sr <= nxt;

  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) cas_q <= 1'b0;
    else        cas_q <= dir_fwd ? sr[N_STAGE-1] : sr[0];

  assign tail_out   = dir_fwd & cas_q;
  assign head_out   = ~dir_fwd & cas_q;
  assign tail_drive = dir_fwd;
  assign head_drive = ~dir_fwd;
endmodule

// File: rtl/gate_scan_chain_chk.sv
module gate_scan_chain_chk #(
  parameter int N_STAGE    = 154,
  parameter int N_HOLD     = 4,
  parameter int HOLD_FIRST = 76,
  parameter int N_PH       = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               dir_fwd,
  input logic               short_mode,
  input logic [N_PH-1:0]    blank,
  input logic [N_STAGE-1:0] sr,
  input logic [N_STAGE-1:0] scan,
  input logic               head_out,
  input logic               tail_out
);
  localparam int HL = HOLD_FIRST - 1;
  localparam int HH = HL + N_HOLD - 1;

  logic [N_PH-1:0][N_STAGE-1:0] pmask;
  always_comb begin
    int k;
    k = 0;
    pmask = '0;
    for (int i = 0; i < N_STAGE; i++) begin
      if (short_mode && i >= HL && i <= HH) continue;
      pmask[k % N_PH][i] = 1'b1;
      k++;
    end
  end

  a_r1_reset_clear: assert property (@(posedge clk) !rst_n |-> (sr == '0));
  a_r2_fwd_step: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dir_fwd) |-> sr[1] == $past(sr[0]));
  a_r3_rev_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(dir_fwd) |-> sr[N_STAGE-2] == $past(sr[N_STAGE-1]));
  a_r4_tail_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_fwd && $past(dir_fwd)) |-> tail_out == sr[N_STAGE-1]);
  a_r4_head_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_fwd && !$past(dir_fwd)) |-> head_out == sr[0]);
  a_r5_gap_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (short_mode && $past(short_mode)) |-> sr[HH:HL] == '0);
  for (genvar p = 0; p < N_PH; p++) begin : g_bl
    a_r6_blank_group: assert property (@(posedge clk) disable iff (!rst_n)
      blank[p] |-> (scan & pmask[p]) == '0);
  end
endmodule

bind gate_scan_chain gate_scan_chain_chk #(
  .N_STAGE(N_STAGE), .N_HOLD(N_HOLD), .HOLD_FIRST(HOLD_FIRST), .N_PH(N_PH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .dir_fwd(dir_fwd), .short_mode(short_mode),
  .blank(blank), .sr(sr), .scan(scan), .head_out(head_out), .tail_out(tail_out)
);

// File: tb/sim_gate_scan_chain.sv
`timescale 1ns/1ps
module sim_gate_scan_chain;
  localparam int N = 154;
  logic clk = 0, rst_n = 0, dir_fwd = 1, short_mode = 0, head_in = 0, tail_in = 0;
  logic [2:0] blank = 0;
  logic [N-1:0] scan;
  logic head_out, tail_out, head_drive, tail_drive;

  gate_scan_chain u0 (.clk(clk), .rst_n(rst_n), .dir_fwd(dir_fwd), .short_mode(short_mode),
    .head_in(head_in), .tail_in(tail_in), .blank(blank), .scan(scan), .head_out(head_out),
    .tail_out(tail_out), .head_drive(head_drive), .tail_drive(tail_drive));

  always #10 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  string cur_req = "R1";
  int path[$];
  int ph [1:N];
  bit refv [1:N];
  bit rcas;

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic compare();
    logic [N-1:0] e;
    for (int n = 1; n <= N; n++) e[n-1] = refv[n] & ~blank[ph[n]];
    chk(cur_req, scan, e);
    chk(cur_req, {tail_out, head_out}, {dir_fwd & rcas, ~dir_fwd & rcas});
    chk("R9", {tail_drive, head_drive}, {dir_fwd, ~dir_fwd});
  endtask

  task automatic reset_cfg(input bit s, input bit f);
    rst_n = 0; short_mode = s; dir_fwd = f; head_in = 0; tail_in = 0; blank = 0;
    path.delete();
    for (int n = 1; n <= N; n++) begin
      refv[n] = 0; ph[n] = 0;
      if (!(s && n >= 76 && n <= 79)) begin ph[n] = path.size() % 3; path.push_back(n); end
    end
    rcas = 0;
    repeat (2) @(negedge clk);
    #5;
    cur_req = "R1"; compare();
    rst_n = 1;
  endtask

  task automatic step();
    int L;
    @(posedge clk);
    L = path.size();
    if (dir_fwd) begin
      for (int k = L - 1; k >= 1; k--) refv[path[k]] = refv[path[k-1]];
      refv[path[0]] = head_in;
    end else begin
      for (int k = 0; k < L - 1; k++) refv[path[k]] = refv[path[k+1]];
      refv[path[L-1]] = tail_in;
    end
    @(negedge clk);
    rcas = dir_fwd ? refv[path[L-1]] : refv[path[0]];
    #5;
    compare();
  endtask

  task automatic run_pulse(input bit s, input bit f);
    int first_hi = 0, hi_cnt = 0, len;
    len = s ? 150 : 154;
    reset_cfg(s, f);
    cur_req = f ? "R2" : "R3";
    if (f) head_in = 1; else tail_in = 1;
    step();
    head_in = 0; tail_in = 0;
    chk(f ? "R2" : "R3", scan, f ? N'(1) : (N'(1) << (N - 1)));
    for (int k = 2; k <= len + 3; k++) begin
      step();
      if ((f ? tail_out : head_out) === 1'b1) begin
        hi_cnt++;
        if (first_hi == 0) first_hi = k;
      end
      if (s && (f ? k == 76 : k == 76)) chk("R5", scan, f ? (N'(1) << 79) : (N'(1) << 74));
    end
    chk(s ? "R5" : "R4", N'(first_hi), N'(len));
    chk(s ? "R5" : "R4", N'(hi_cnt), N'(1));
  endtask

  task automatic run_random(input bit s, input bit f, input int cnt);
    reset_cfg(s, f);
    cur_req = s ? "R8" : "R7";
    for (int k = 0; k < cnt; k++) begin
      head_in = ($urandom % 3) == 0;
      tail_in = ($urandom % 3) == 0;
      blank = (($urandom % 4) == 0) ? 3'($urandom) : 3'b000;
      step();
    end
    blank = 0;
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    run_pulse(0, 1);
    run_pulse(0, 0);
    run_pulse(1, 1);
    run_pulse(1, 0);

    // long mode blank and phase mapping
    reset_cfg(0, 1);
    cur_req = "R6";
    head_in = 1;
    repeat (9) step();
    head_in = 0;
    blank = 3'b001; #1; compare();
    chk("R7", N'(scan[3]), N'(0));
    chk("R7", N'(scan[4]), N'(1));
    blank = 3'b111; #1;
    chk("R6", scan, '0);
    step(); step();
    chk("R6", scan, '0);
    blank = 3'b000; #1;
    chk("R6", scan, N'(12'h7FC));

    // short mode phase mapping
    reset_cfg(1, 1);
    cur_req = "R8";
    head_in = 1;
    repeat (85) step();
    head_in = 0;
    blank = 3'b001; #1; compare();
    chk("R8", {scan[80], scan[79], scan[74]}, N'(3'b101));
    blank = 3'b010; #1; compare();
    chk("R8", {scan[80], scan[79]}, N'(2'b01));
    chk("R5", N'(scan[78:75]), N'(0));
    blank = 3'b000;

    run_random(0, 1, 300);
    run_random(0, 0, 300);
    run_random(1, 1, 300);
    run_random(1, 0, 300);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule